// File: doc/BRIEF.md
# Programmable Input Glitch Filter

This block cleans one raw, asynchronous digital input before that line is used as a trigger, a clock or a counter source. The input is first brought into the clock domain by a short synchronizer chain. A new level then reaches the filtered output only after it has stayed unchanged for a chosen number of filter-clock ticks. Any shorter excursion is dropped, and the output keeps its old level.

The filter clock does not run as a separate clock. It arrives as two tick enables on the system clock: a fast one with a 12.5 ns period and a slow one with a 10 µs period. A two-bit setting chooses one of four behaviours: a bypass, or one of three fixed presets. Each preset has its own tick source and its own exact threshold. The pass width and the reject width of a preset lie exactly one tick apart. A custom override replaces the presets with a programmable count of fast ticks.

Top module: `pulse_glitch_filter`

## Requirements
- R1: After reset the filtered output is low. It stays low until the input has been high for the full threshold.
- R2: With `flt_mode` = 2'b00 and `cust_en` low, the filter is bypassed. The output takes each synchronized input level with a latency of three clock edges, and a one-cycle pulse passes.
- R3: With `flt_mode` = 2'b01, the filter counts fast ticks and the threshold is 9. A level held for 9 ticks passes (112.5 ns). A level held for 8 ticks is rejected (100 ns).
- R4: With `flt_mode` = 2'b10, the filter counts fast ticks and the threshold is 512. A level held for 512 ticks passes (6.4 µs). A level held for 511 ticks is rejected.
- R5: With `flt_mode` = 2'b11, the filter counts slow ticks only and the threshold is 256. A level held for 256 ticks passes (2.56 ms). A level held for 255 ticks is rejected. Fast ticks have no effect in this setting.
- R6: When `cust_en` is high, it overrides `flt_mode`. The threshold is then `cust_ticks` fast ticks, and a value of 0 acts as 1.
- R7: The stability count advances only on clock edges where the selected tick enable is high. Without ticks, the output never changes while the filter is active.
- R8: The count restarts whenever the synchronized input equals the output. A one-cycle return to the old level therefore breaks up two short pulses that, added together, would exceed the threshold.
- R9: A change of any setting input (`cust_en`, `flt_mode` or `cust_ticks`) clears the count on the next edge. A level must then be held for the full new threshold.
- R10: Rising and falling transitions are filtered the same way.
- R11: With the tick enable held high, the output changes exactly THR+2 clock edges after the raw input changes, where THR is the active threshold. The output only ever moves toward the synchronized input level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_base | input | 1 | Fast filter tick enable (12.5 ns period) |
| tick_slow | input | 1 | Slow filter tick enable (10 µs period) |
| din_raw | input | 1 | Raw asynchronous input line |
| flt_mode | input | 2 | Preset: 00 bypass, 01 short, 10 medium, 11 long |
| cust_en | input | 1 | Use the custom threshold instead of the preset |
| cust_ticks | input | CNT_W | Custom threshold in fast ticks (0 treated as 1) |
| dout | output | 1 | Filtered output |

## Verification
Single pulses sit exactly at each preset's pass width and one tick below it. This separates an off-by-one threshold from a correct one, in both directions and at every tick source. Each pulse is sampled one edge before and at the expected switching edge, so the timing is checked as well as the decision. Pulses split by a one-cycle gap show whether the count restarts. A setting change in the middle of a pulse shows whether the count is cleared. Runs with the tick enable held low separate gated counting from free counting. Seeded random pulse widths around random custom thresholds cover the rest of the width range.

// File: rtl/glf_pkg.sv
package glf_pkg;

    typedef enum logic [1:0] {
        FLT_BYPASS = 2'b00,
        FLT_SHORT  = 2'b01,
        FLT_MEDIUM = 2'b10,
        FLT_LONG   = 2'b11
    } flt_mode_e;

endpackage

// File: rtl/glf_sync.sv
module glf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] stage_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= 1'b0;
                    else        stage_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= 1'b0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/glf_thr_sel.sv
module glf_thr_sel
    import glf_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SHORT_TICKS = 9,
    parameter int MED_TICKS   = 512,
    parameter int LONG_TICKS  = 256
) (
    input  flt_mode_e        mode_i,
    input  logic             cust_en_i,
    input  logic [CNT_W-1:0] cust_ticks_i,
    input  logic             tick_base_i,
    input  logic             tick_slow_i,
    output logic [CNT_W-1:0] thr_o,
    output logic             tick_o,
    output logic             bypass_o
);
    always_comb begin
        thr_o    = CNT_W'(1);
        tick_o   = tick_base_i;
        bypass_o = 1'b0;
        if (cust_en_i) begin
            thr_o = (cust_ticks_i == '0) ? CNT_W'(1) : cust_ticks_i;
        end else begin
            unique case (mode_i)
                FLT_BYPASS: bypass_o = 1'b1;
                FLT_SHORT:  thr_o    = CNT_W'(SHORT_TICKS);
                FLT_MEDIUM: thr_o    = CNT_W'(MED_TICKS);
                FLT_LONG: begin
                    thr_o  = CNT_W'(LONG_TICKS);
                    tick_o = tick_slow_i;
                end
                default:    bypass_o = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/pulse_glitch_filter.sv
module pulse_glitch_filter
    import glf_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int SHORT_TICKS = 9,
    parameter int MED_TICKS   = 512,
    parameter int LONG_TICKS  = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_base,
    input  logic             tick_slow,
    input  logic             din_raw,
    input  logic [1:0]       flt_mode,
    input  logic             cust_en,
    input  logic [CNT_W-1:0] cust_ticks,
    output logic             dout
);
    localparam int SET_W = 3 + CNT_W;
    localparam int EXT_W = CNT_W + 1;

    typedef struct packed {
        logic [SET_W-1:0] setting;
        logic [CNT_W-1:0] cnt;
        logic             out;
    } state_t;

    state_t           st_d, st_q;
    logic             sync_w;
    logic [CNT_W-1:0] thr_w;
    logic [CNT_W-1:0] cnt_w;
    logic             tick_w;
    logic             byp_w;
    logic             chg_w;
    logic             hit_w;
    logic [SET_W-1:0] set_now;

    glf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (din_raw),
        .q_o   (sync_w)
    );

    glf_thr_sel #(
        .CNT_W       (CNT_W),
        .SHORT_TICKS (SHORT_TICKS),
        .MED_TICKS   (MED_TICKS),
        .LONG_TICKS  (LONG_TICKS)
    ) u_sel (
        .mode_i       (flt_mode_e'(flt_mode)),
        .cust_en_i    (cust_en),
        .cust_ticks_i (cust_ticks),
        .tick_base_i  (tick_base),
        .tick_slow_i  (tick_slow),
        .thr_o        (thr_w),
        .tick_o       (tick_w),
        .bypass_o     (byp_w)
    );

    assign set_now = {cust_en, flt_mode, cust_ticks};
    assign chg_w   = (set_now != st_q.setting);
    assign hit_w   = ({1'b0, st_q.cnt} + EXT_W'(1)) >= {1'b0, thr_w};

    always_comb begin
        st_d         = st_q;
        st_d.setting = set_now;
        if (byp_w) begin
            st_d.out = sync_w;
            st_d.cnt = '0;
        end else if (chg_w || (sync_w == st_q.out)) begin
            st_d.cnt = '0;
        end else if (tick_w) begin
            if (hit_w) begin
                st_d.out = sync_w;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_w = st_q.cnt;
    assign dout  = st_q.out;
endmodule

// File: rtl/pulse_glitch_filter_chk.sv
module pulse_glitch_filter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dout,
    input logic             sync_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic [CNT_W-1:0] thr_i,
    input logic             tick_i,
    input logic             byp_i,
    input logic             chg_i
);
    AST_RESET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dout); // R1

    AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        byp_i |=> (dout == $past(sync_i))); // R2

    AST_SWITCH_AT_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dout) && !$past(byp_i)) |->
        (({1'b0, $past(cnt_i)} + (CNT_W + 1)'(1)) == {1'b0, $past(thr_i)})); // R3

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp_i && !tick_i) |=> $stable(dout)); // R7

    AST_MATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp_i && (sync_i == dout)) |=> (cnt_i == '0)); // R8

    AST_SETTING_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        chg_i |=> (cnt_i == '0)); // R9

    AST_TOWARD_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> (dout == $past(sync_i))); // R11
endmodule

bind pulse_glitch_filter pulse_glitch_filter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .dout   (dout),
    .sync_i (sync_w),
    .cnt_i  (cnt_w),
    .thr_i  (thr_w),
    .tick_i (tick_w),
    .byp_i  (byp_w),
    .chg_i  (chg_w)
);

// File: tb/pulse_glitch_filter_tb.sv
module pulse_glitch_filter_tb;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_base = 1'b1;
    logic             tick_slow = 1'b0;
    logic             din_raw = 1'b0;
    logic [1:0]       flt_mode = 2'b01;
    logic             cust_en = 1'b0;
    logic [CNT_W-1:0] cust_ticks = '0;
    logic             dout;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pulse_glitch_filter #(.CNT_W(CNT_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_base  (tick_base),
        .tick_slow  (tick_slow),
        .din_raw    (din_raw),
        .flt_mode   (flt_mode),
        .cust_en    (cust_en),
        .cust_ticks (cust_ticks),
        .dout       (dout)
    );

    function automatic logic exp_after(input logic old, input int w, input int thr);
        return (w >= thr) ? ~old : old;
    endfunction

    task automatic chk(input logic got, input logic exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: dout=%0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic settle(input logic lvl, input int thr);
        din_raw = lvl;
        repeat (thr + 6) @(negedge clk);
    endtask

    // pulse of the opposite level for w cycles; sampled one edge early and at edge thr+2
    task automatic pulse_chk(input int w, input int thr, input string tag);
        logic old;
        logic early;
        logic at_edge;
        int   len;
        old     = dout;
        early   = old;
        at_edge = old;
        len     = (w > thr + 2) ? w : thr + 2;
        din_raw = ~old;
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            if (i == w)       din_raw = old;
            if (i == thr + 1) early   = dout;
            if (i == thr + 2) at_edge = dout;
        end
        chk(early, old, {tag, " one edge early (R11)"});
        chk(at_edge, exp_after(old, w, thr), {tag, " at switching edge"});
        repeat (thr + 6) @(negedge clk);
        chk(dout, old, {tag, " restored (R10)"});
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        int thr;
        int w;
        bit seen;
        void'($urandom(32'd7331));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dout, 1'b0, "R1 reset level");

        // R1 / R3 short preset, rising then falling
        pulse_chk(9, 9, "R3 short 9 ticks");
        pulse_chk(8, 9, "R3 short 8 ticks");
        pulse_chk(1, 9, "R1 single-cycle glitch");
        settle(1'b1, 9);
        chk(dout, 1'b1, "R10 settle high");
        pulse_chk(9, 9, "R10 falling 9 ticks");
        pulse_chk(8, 9, "R10 falling 8 ticks");
        settle(1'b0, 9);

        // R8 interrupted pulses
        seen = 1'b0;
        din_raw = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (i == 4)  din_raw = 1'b0;
            if (i == 5)  din_raw = 1'b1;
            if (i == 10) din_raw = 1'b0;
            if (dout) seen = 1'b1;
        end
        chk(seen, 1'b0, "R8 split pulse rejected");

        // R7 tick gating
        tick_base = 1'b0;
        din_raw = 1'b1;
        repeat (40) @(negedge clk);
        chk(dout, 1'b0, "R7 no ticks no change");
        tick_base = 1'b1;
        repeat (8) @(negedge clk);
        chk(dout, 1'b0, "R7 eight ticks");
        @(negedge clk);
        chk(dout, 1'b1, "R7 ninth tick");
        settle(1'b0, 9);

        // R2 bypass
        flt_mode = 2'b00;
        repeat (3) @(negedge clk);
        pulse_chk(1, 1, "R2 bypass one cycle");
        pulse_chk(4, 1, "R2 bypass four cycles");

        // R4 medium preset
        flt_mode = 2'b10;
        repeat (3) @(negedge clk);
        pulse_chk(512, 512, "R4 medium 512 ticks");
        pulse_chk(511, 512, "R4 medium 511 ticks");

        // R5 long preset on slow ticks only
        flt_mode  = 2'b11;
        tick_base = 1'b0;
        tick_slow = 1'b1;
        repeat (3) @(negedge clk);
        pulse_chk(256, 256, "R5 long 256 ticks");
        pulse_chk(255, 256, "R5 long 255 ticks");
        tick_base = 1'b1;
        tick_slow = 1'b0;
        din_raw   = 1'b1;
        repeat (300) @(negedge clk);
        chk(dout, 1'b0, "R5 fast ticks ignored");
        tick_slow = 1'b1;
        settle(1'b0, 4);
        tick_slow = 1'b0;

        // R6 custom override
        cust_ticks = 16'd0;
        cust_en    = 1'b1;
        repeat (3) @(negedge clk);
        pulse_chk(1, 1, "R6 custom zero acts as one");
        cust_ticks = 16'd20;
        repeat (3) @(negedge clk);
        pulse_chk(20, 20, "R6 custom 20 ticks");
        pulse_chk(19, 20, "R6 custom 19 ticks");

        // R9 setting change restarts the count
        cust_en    = 1'b0;
        flt_mode   = 2'b01;
        cust_ticks = 16'd9;
        repeat (3) @(negedge clk);
        din_raw = 1'b1;
        repeat (6) @(negedge clk);
        cust_en = 1'b1;
        repeat (9) @(negedge clk);
        chk(dout, 1'b0, "R9 count cleared by setting change");
        @(negedge clk);
        chk(dout, 1'b1, "R9 full threshold after change");
        settle(1'b0, 9);

        // constrained random pulses around the threshold
        for (int k = 0; k < 40; k++) begin
            if ($urandom % 2 == 0) begin
                cust_en = 1'b0;
                thr     = 9;
            end else begin
                cust_en    = 1'b1;
                thr        = 1 + int'($urandom % 30);
                cust_ticks = CNT_W'(thr);
            end
            repeat (3) @(negedge clk);
            if ($urandom % 4 == 0) settle(~dout, thr);
            w = 1 + int'($urandom % (thr + 3));
            pulse_chk(w, thr, (cust_en ? "R6 random custom" : "R3 random short"));
        end

        finish_run();
    end
endmodule